// File: doc/BRIEF.md
# PWM Dead-Band Generator

The block takes two raw PWM levels, A and B, and turns them into two gate-drive levels for one leg of a half-bridge, putting a programmable dead time between the switching of the two transistors. A rising-edge delay path holds back the turn-on of its source by a set number of clock cycles. A falling-edge delay path holds back the turn-off of its source in the same way. Each path has its own count. Three control fields choose which input feeds each path, which output takes a delayed signal or the raw input, and which outputs are inverted. Inversion is applied after the delay stage.

The PWM inputs are continuous levels that are sampled on every clock, so they carry no valid/ready handshake and cannot be back-pressured. Each sample stands for one clock of PWM time. A write port loads the control word and the two delay counts. Every path from the inputs to the outputs ends in one output register, so with zero delay an output follows its input one cycle later. Both delay paths use a down-counter. The counter is reloaded with the programmed count whenever its source is at the inactive level, so it starts again on every qualifying edge. A pulse shorter than the dead time therefore never reaches the delayed output. The block has one clock and a synchronous, active-high reset.

Top module: `deadband_gen`

## Requirements
- R1: While reset is high, both gate outputs are 0 from the next clock edge on. Reset clears the control word to output mode 0, polarity 0 and input mode 0, and sets both delay counts to 0.
- R2: A write with wr_en high at a clock edge updates the register at wr_addr, and the new value applies from the next cycle. Address 0 is the control word: bits [1:0] output mode, bits [3:2] polarity, bits [5:4] input mode. Address 1 is the rising-edge delay and address 2 is the falling-edge delay, each taken from wr_data[CNT_W-1:0]. With wr_en low, no register changes.
- R3: Input mode bit 0 selects the rising-path source (0 = A, 1 = B). Input mode bit 1 selects the falling-path source (0 = A, 1 = B). So 0 gives A to both paths, 1 gives B rising and A falling, 2 gives A rising and B falling, and 3 gives B to both paths.
- R4: With a rising-edge delay of N, the rising-path signal goes high N cycles after its source goes high, and it goes low in the same cycle as its source.
- R5: With a falling-edge delay of N, the falling-path signal goes low N cycles after its source goes low, and it goes high in the same cycle as its source.
- R6: A high pulse shorter than the rising delay never appears on the rising path. A low pulse shorter than the falling delay never appears on the falling path.
- R7: Output mode 0 sends input A to output A and input B to output B, each with one cycle of latency.
- R8: Output mode 1 sends raw input A to output A and the falling-path signal to output B.
- R9: Output mode 2 sends the rising-path signal to output A and raw input B to output B.
- R10: Output mode 3 sends the rising-path signal to output A and the falling-path signal to output B.
- R11: Polarity bit 0 inverts output A and bit 1 inverts output B. Value 0 inverts neither, 1 inverts A, 2 inverts B and 3 inverts both. Inversion is applied after the delay stage.
- R12: A delay count of 0 passes edges through with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 rising delay, 2 falling delay |
| wr_data | input | DATA_W | Write data |
| pwm_a_in | input | 1 | Raw PWM level A |
| pwm_b_in | input | 1 | Raw PWM level B |
| gate_a | output | 1 | Gate-drive output A |
| gate_b | output | 1 | Gate-drive output B |

## Verification
The assertions check on every cycle:
- the clearing of both outputs under reset;
- the loading of a delay register and the hold of all registers when no write is strobed;
- the one-cycle path in bypass mode, with and without double inversion;
- the rule that a delayed high on A, or a delayed low on B, is only seen when its source had the same level.

The exact edge placement needs the bench's scenarios. This covers the count of cycles before a delayed edge, the restart after a short break, the removal of short pulses, the routing for each input-mode and output-mode pair, and the inversion of an already delayed edge.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

  typedef enum logic [1:0] {
    OM_BYPASS    = 2'd0,
    OM_FALL_ONLY = 2'd1,
    OM_RISE_ONLY = 2'd2,
    OM_BOTH      = 2'd3
  } outmode_e;

  // Field order matches control word bits [5:0]
  typedef struct packed {
    logic [1:0] in_sel;   // [5:4]
    logic [1:0] pol;      // [3:2]
    outmode_e   mode;     // [1:0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RED  = 2'd1;
  localparam logic [1:0] ADDR_FED  = 2'd2;

endpackage

// File: rtl/deadband_regs.sv
module deadband_regs
  import deadband_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  red_dly,
  output logic [CNT_W-1:0]  fed_dly
);

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '{in_sel: 2'd0, pol: 2'd0, mode: OM_BYPASS};
      red_dly <= '0;
      fed_dly <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_RED:  red_dly <= wr_data[CNT_W-1:0];
        ADDR_FED:  fed_dly <= wr_data[CNT_W-1:0];
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/deadband_delay.sv
module deadband_delay #(
  parameter int CNT_W  = 10,
  parameter bit RISING = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src,
  input  logic [CNT_W-1:0] dly,
  output logic             dout
);

  logic [CNT_W-1:0] cnt;
  logic             idle;
  logic             expired;

  // The inactive level of the source reloads the counter
  assign idle    = RISING ? ~src : src;
  assign expired = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (idle)      cnt <= dly;
    else if (!expired)  cnt <= cnt - 1'b1;
  end

  generate
    if (RISING) begin : g_rise
      assign dout = src & expired;
    end else begin : g_fall
      assign dout = src | ~expired;
    end
  endgenerate

endmodule

// File: rtl/deadband_outsel.sv
module deadband_outsel
  import deadband_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl,
  input  logic  raw_a,
  input  logic  raw_b,
  input  logic  red_sig,
  input  logic  fed_sig,
  output logic  gate_a,
  output logic  gate_b
);

  logic pre_a, pre_b;

  always_comb begin
    pre_a = raw_a;
    pre_b = raw_b;
    case (ctrl.mode)
      OM_BYPASS:    begin pre_a = raw_a;   pre_b = raw_b;   end
      OM_FALL_ONLY: begin pre_a = raw_a;   pre_b = fed_sig; end
      OM_RISE_ONLY: begin pre_a = red_sig; pre_b = raw_b;   end
      OM_BOTH:      begin pre_a = red_sig; pre_b = fed_sig; end
      default:      ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_a <= 1'b0;
      gate_b <= 1'b0;
    end else begin
      gate_a <= pre_a ^ ctrl.pol[0];
      gate_b <= pre_b ^ ctrl.pol[1];
    end
  end

endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
  import deadband_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pwm_a_in,
  input  logic              pwm_b_in,
  output logic              gate_a,
  output logic              gate_b
);

  localparam int NPATH = 2;  // index 0 rising, 1 falling

  ctrl_t            ctrl;
  logic [CNT_W-1:0] red_dly, fed_dly;
  logic [CNT_W-1:0] path_dly [NPATH];
  logic             path_src [NPATH];
  logic             path_out [NPATH];

  deadband_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .red_dly(red_dly), .fed_dly(fed_dly)
  );

  assign path_src[0] = ctrl.in_sel[0] ? pwm_b_in : pwm_a_in;
  assign path_src[1] = ctrl.in_sel[1] ? pwm_b_in : pwm_a_in;
  assign path_dly[0] = red_dly;
  assign path_dly[1] = fed_dly;

  generate
    for (genvar g = 0; g < NPATH; g++) begin : g_path
      deadband_delay #(.CNT_W(CNT_W), .RISING(g == 0)) u_dly (
        .clk(clk), .rst(rst), .src(path_src[g]),
        .dly(path_dly[g]), .dout(path_out[g])
      );
    end
  endgenerate

  deadband_outsel u_out (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .raw_a(pwm_a_in), .raw_b(pwm_b_in),
    .red_sig(path_out[0]), .fed_sig(path_out[1]),
    .gate_a(gate_a), .gate_b(gate_b)
  );

endmodule

// File: rtl/deadband_gen_chk.sv
module deadband_gen_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              pwm_a_in,
  input logic              pwm_b_in,
  input logic              gate_a,
  input logic              gate_b,
  input logic [1:0]        cfg_mode,
  input logic [1:0]        cfg_pol,
  input logic [1:0]        cfg_in,
  input logic [CNT_W-1:0]  red_dly
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!gate_a && !gate_b));

  // R2
  red_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd1) |=> (red_dly == $past(wr_data[CNT_W-1:0])));

  // R2
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(red_dly) && $stable(cfg_mode) && $stable(cfg_pol) && $stable(cfg_in)));

  // R7
  bypass_path_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd0 && cfg_pol == 2'd0) |=>
      (gate_a == $past(pwm_a_in) && gate_b == $past(pwm_b_in)));

  // R11
  invert_both_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd0 && cfg_pol == 2'd3) |=>
      (gate_a == !$past(pwm_a_in) && gate_b == !$past(pwm_b_in)));

  // R4
  rise_source_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_a && $past(cfg_mode[1] && !cfg_pol[0] && !cfg_in[0])) |-> $past(pwm_a_in));

  // R5
  fall_source_chk: assert property (@(posedge clk) disable iff (rst)
    (!gate_b && $past(cfg_mode[0] && !cfg_pol[1] && !cfg_in[1])) |-> !$past(pwm_a_in));

endmodule

bind deadband_gen deadband_gen_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in), .gate_a(gate_a), .gate_b(gate_b),
  .cfg_mode(ctrl.mode), .cfg_pol(ctrl.pol), .cfg_in(ctrl.in_sel), .red_dly(red_dly)
);

// File: tb/deadband_gen_test.sv
module deadband_gen_test;

  localparam int DATA_W = 16;
  localparam int CNT_W  = 10;
  localparam int NVEC   = 12;

  // {ctrl[5:0] = {in_sel, pol, mode}, a, b, exp_a, exp_b}
  localparam logic [9:0] VEC [NVEC] = '{
    {6'b00_00_00, 1'b1, 1'b0, 1'b1, 1'b0},  // R7
    {6'b00_11_00, 1'b1, 1'b0, 1'b0, 1'b1},  // R11
    {6'b00_01_00, 1'b0, 1'b0, 1'b1, 1'b0},  // R11
    {6'b00_10_00, 1'b0, 1'b0, 1'b0, 1'b1},  // R11
    {6'b00_00_11, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 R10
    {6'b11_00_11, 1'b0, 1'b1, 1'b1, 1'b1},  // R3
    {6'b01_00_11, 1'b0, 1'b1, 1'b1, 1'b0},  // R3
    {6'b10_00_11, 1'b0, 1'b1, 1'b0, 1'b1},  // R3
    {6'b00_00_01, 1'b0, 1'b1, 1'b0, 1'b0},  // R8
    {6'b00_00_10, 1'b1, 1'b0, 1'b1, 1'b0},  // R9
    {6'b11_10_10, 1'b0, 1'b1, 1'b1, 1'b0},  // R9 R11
    {6'b11_01_01, 1'b0, 1'b1, 1'b1, 1'b1}   // R8 R11
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              pwm_a = 1'b0;
  logic              pwm_b = 1'b0;
  logic              gate_a, gate_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit seen;

  always #10 clk = ~clk;

  deadband_gen #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_a_in(pwm_a), .pwm_b_in(pwm_b), .gate_a(gate_a), .gate_b(gate_b)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] addr, input logic [DATA_W-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(3);
    check("R1 reset gate_a", gate_a, 1'b0);
    check("R1 reset gate_b", gate_b, 1'b0);
    rst = 1'b0;

    // table walk, delays zero (R12)
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, {10'd0, VEC[i][9:4]});
      pwm_a = VEC[i][3];
      pwm_b = VEC[i][2];
      settle(2);
      check($sformatf("R3/R7/R8/R9/R10/R11 vec %0d gate_a", i), gate_a, VEC[i][1]);
      check($sformatf("R3/R7/R8/R9/R10/R11 vec %0d gate_b", i), gate_b, VEC[i][0]);
    end

    // R2: write strobe low leaves the control word alone
    @(negedge clk);
    wr_addr = 2'd0; wr_data = '0; wr_en = 1'b0;
    settle(3);
    check("R2 no-strobe gate_a", gate_a, 1'b1);
    check("R2 no-strobe gate_b", gate_b, 1'b1);

    // R4: rising delay of 4, both paths from A, mode 3
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0003);
    pwm_a = 1'b0; pwm_b = 1'b0;
    settle(6);
    pwm_a = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check($sformatf("R4 rise hold k=%0d", k), gate_a, 1'b0);
      if (k == 1) check("R12 zero falling delay follows", gate_b, 1'b1);
    end
    @(negedge clk);
    check("R4 rise after 4", gate_a, 1'b1);

    // R5: falling delay of 3
    wr(2'd2, 16'd3);
    settle(2);
    pwm_a = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (k == 1) check("R4 falls with source", gate_a, 1'b0);
      check($sformatf("R5 fall hold k=%0d", k), gate_b, 1'b1);
    end
    @(negedge clk);
    check("R5 fall after 3", gate_b, 1'b0);

    // R6: short high pulse removed from rising path
    settle(6);
    pwm_a = 1'b1;
    settle(2);
    pwm_a = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (gate_a) seen = 1'b1;
    end
    check("R6 short high pulse removed", seen, 1'b0);

    // R6: short low pulse removed from falling path
    pwm_a = 1'b1;
    settle(8);
    pwm_a = 1'b0;
    settle(2);
    pwm_a = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!gate_b) seen = 1'b1;
    end
    check("R6 short low pulse removed", seen, 1'b0);

    // R4: counter restarts after a one-cycle break
    pwm_a = 1'b0;
    settle(6);
    pwm_a = 1'b1;
    settle(3);
    pwm_a = 1'b0;
    settle(1);
    pwm_a = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check($sformatf("R4 restart hold k=%0d", k), gate_a, 1'b0);
    end
    @(negedge clk);
    check("R4 restart rise", gate_a, 1'b1);

    // R11: inversion applied after the rising delay
    pwm_a = 1'b0;
    wr(2'd0, 16'h0007);  // mode 3, pol 1
    settle(6);
    check("R11 inverted idle", gate_a, 1'b1);
    pwm_a = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check($sformatf("R11 inverted hold k=%0d", k), gate_a, 1'b1);
    end
    @(negedge clk);
    check("R11 inverted delayed edge", gate_a, 1'b0);

    // R9: mode 2 leaves B undelayed
    wr(2'd0, 16'h0002);
    pwm_b = 1'b1;
    settle(4);
    pwm_b = 1'b0;
    @(negedge clk);
    check("R9 raw B no falling delay", gate_b, 1'b0);

    // R8: mode 1 leaves A undelayed
    wr(2'd0, 16'h0001);
    pwm_a = 1'b0;
    settle(4);
    pwm_a = 1'b1;
    @(negedge clk);
    check("R8 raw A no rising delay", gate_a, 1'b1);

    // R1: reset mid-run clears outputs and configuration
    wr(2'd0, 16'h000F);
    pwm_a = 1'b1; pwm_b = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    settle(2);
    check("R1 mid-run reset gate_a", gate_a, 1'b0);
    check("R1 mid-run reset gate_b", gate_b, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cleared config bypass gate_a", gate_a, 1'b1);
    check("R1 cleared config bypass gate_b", gate_b, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule